// File: doc/BRIEF.md
# Low-Speed Clock Source Selector

This block picks where the low-speed timekeeping tick comes from. One source is an internal oscillator, whose tick is slowed by a programmable divide-by-(N+1) prescaler. The other is an external 32 kHz crystal, whose tick passes through undivided. Both sources reach the block as one-cycle enable pulses in the system clock domain. The block therefore models the source multiplexer as a choice between tick enables, not as a clock switch.

Software controls the block through a small word-addressed register bus. The source-select register has a guard: a write changes it only when the upper half-word of the write data holds the unlock key 0x16AA. This stops a stray store from moving the timekeeping clock onto the wrong source. A separate gate register decides whether the selected tick is forwarded to the clock output.

Top module: `lsclk_select`

## Requirements
- R1: After reset the internal source is selected, the prescaler value is 0 and the output gate is off, so reads at offsets 0x00, 0x08 and 0x60 all return zero.
- R2: A write to offset 0x00 updates the source select bit (bit 0: 1 = external, 0 = internal) only when write data bits 31:16 equal 0x16AA. A write with any other key value leaves the selection unchanged.
- R3: A read at offset 0x00 returns the current source select in bit 0. All other bits read as zero, including the key field.
- R4: Offset 0x08 holds a 5-bit prescaler value P in bits 4:0, and reads return it in bits 4:0 with the other bits zero. While the internal source is selected, the selected tick fires on every (P+1)-th internal tick pulse, counted from the last counter restart.
- R5: While the external source is selected, the selected tick equals the external tick input in every cycle. Internal ticks and the prescaler value then have no effect.
- R6: Offset 0x60 bit 0 is the output gate. The gated output tick equals the selected tick when the gate is 1 and is 0 when the gate is 0. Reads return the gate in bit 0.
- R7: The prescaler count restarts from zero when a write changes the prescaler value or when an accepted write switches the source. A write that leaves both unchanged does not restart the count.
- R8: Writes to any other offset change nothing, and reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| int_tick | input | 1 | Tick enable from the internal oscillator |
| ext_tick | input | 1 | Tick enable from the external crystal |
| lsclk_tick | output | 1 | Selected low-speed tick |
| lsclk_out_tick | output | 1 | Selected tick after the output gate |

## Verification
The bench attacks the key guard from several directions: no key, a key that is off by one, and the correct key with junk in the other bits. A design that tested the wrong half-word, or that stored the key field, would flip the source or read back nonzero upper bits. It checks the tick count for a prescaler of 0, 2 and 31. An off-by-one divider would show up as an extra or a missing tick. It also checks the counter restart: writing the same prescaler value must not restart the count, while changing the value or toggling the source and back must restart it. A design that always restarts, or never restarts, would produce a tick one or two pulses off. Finally, the gate and unmapped-offset checks catch output leaking through a closed gate, and address decoding that aliases onto the three registers.

// File: rtl/lsclk_select.sv
module lsclk_select #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32,
  parameter int unsigned PW = 5,
  parameter int unsigned KW = 16,
  parameter logic [KW-1:0] KEY = 16'h16AA,
  parameter logic [AW-1:0] OFF_CTRL = 8'h00,
  parameter logic [AW-1:0] OFF_PRE  = 8'h08,
  parameter logic [AW-1:0] OFF_GATE = 8'h60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          int_tick,
  input  logic          ext_tick,
  output logic          lsclk_tick,
  output logic          lsclk_out_tick
);

  logic          src_q, gate_q;
  logic [PW-1:0] pre_q, cnt_q;

  wire key_ok  = bus_wdata[DW-1 -: KW] == KEY;
  wire ctrl_wr = bus_wr && bus_addr == OFF_CTRL && key_ok;
  wire pre_wr  = bus_wr && bus_addr == OFF_PRE;
  wire gate_wr = bus_wr && bus_addr == OFF_GATE;
  wire restart = (pre_wr && bus_wdata[PW-1:0] != pre_q) ||
                 (ctrl_wr && bus_wdata[0] != src_q);
  wire wrap    = cnt_q == pre_q;

  assign lsclk_tick     = src_q ? ext_tick : (int_tick && wrap);
  assign lsclk_out_tick = lsclk_tick && gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      gate_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      if (ctrl_wr) src_q  <= bus_wdata[0];
      if (gate_wr) gate_q <= bus_wdata[0];
      if (pre_wr)  pre_q  <= bus_wdata[PW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart)           cnt_q <= '0;
    else if (!src_q && int_tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CTRL: bus_rdata[0]      = src_q;
      OFF_PRE:  bus_rdata[PW-1:0] = pre_q;
      OFF_GATE: bus_rdata[0]      = gate_q;
      default:  bus_rdata = '0;
    endcase
  end

  p_key_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_CTRL && bus_wdata[DW-1 -: KW] != KEY) |=> $stable(src_q));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= pre_q);

  p_int_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_q && lsclk_tick) |-> int_tick);

  p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lsclk_out_tick |-> (gate_q && lsclk_tick));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_wr && bus_wdata[PW-1:0] != pre_q) |=> cnt_q == '0);

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != OFF_CTRL && bus_addr != OFF_PRE && bus_addr != OFF_GATE)
    |=> ($stable(src_q) && $stable(pre_q) && $stable(gate_q)));

endmodule

// File: tb/lsclk_select_bench.sv
module lsclk_select_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        int_tick = 1'b0, ext_tick = 1'b0;
  logic        lsclk_tick, lsclk_out_tick;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  lsclk_select u_lsclk_select (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_tick(int_tick),
    .ext_tick(ext_tick), .lsclk_tick(lsclk_tick), .lsclk_out_tick(lsclk_out_tick));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse_int(input int n, output int ticks);
    ticks = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); int_tick = 1'b1; #1;
      if (lsclk_tick) ticks++;
    end
    @(negedge clk); int_tick = 1'b0;
  endtask

  task automatic t_reset;
    rd_check("R1 ctrl", 8'h00, 0);
    rd_check("R1 pre", 8'h08, 0);
    rd_check("R1 gate", 8'h60, 0);
  endtask

  task automatic t_key;
    wr(8'h00, 32'h0000_0001); rd_check("R2 no key", 8'h00, 0);
    wr(8'h00, 32'h16AB_0001); rd_check("R2 near key", 8'h00, 0);
    wr(8'h00, 32'h16AA_FFFF); rd_check("R3 readback", 8'h00, 32'h1);
    wr(8'h00, 32'h0000_0000); rd_check("R2 clear no key", 8'h00, 32'h1);
    wr(8'h00, 32'h16AA_0000); rd_check("R2 keyed clear", 8'h00, 0);
  endtask

  task automatic t_divide;
    int t;
    pulse_int(5, t); check("R4 div1", t, 5);
    wr(8'h08, 32'hFFFF_FFE2); rd_check("R4 pre read", 8'h08, 32'h2);
    pulse_int(9, t); check("R4 div3", t, 3);
    wr(8'h08, 32'h1F);
    pulse_int(64, t); check("R4 div32", t, 2);
  endtask

  task automatic t_restart;
    int t;
    wr(8'h08, 3);
    pulse_int(2, t); check("R7 pre-run", t, 0);
    wr(8'h08, 3);
    pulse_int(2, t); check("R7 same value keeps count", t, 1);
    pulse_int(2, t);
    wr(8'h08, 2);
    pulse_int(2, t); check("R7 change restarts", t, 0);
    pulse_int(1, t); check("R7 third pulse", t, 1);
    pulse_int(2, t);
    wr(8'h00, 32'h16AA_0001); wr(8'h00, 32'h16AA_0000);
    pulse_int(2, t); check("R7 switch restarts", t, 0);
    pulse_int(1, t); check("R7 switch third", t, 1);
  endtask

  task automatic t_ext_gate;
    wr(8'h00, 32'h16AA_0001);
    @(negedge clk); int_tick = 1'b1; ext_tick = 1'b0; #1;
    check("R5 int ignored", lsclk_tick, 0);
    @(negedge clk); ext_tick = 1'b1; #1;
    check("R5 ext passes", lsclk_tick, 1);
    check("R6 gate closed", lsclk_out_tick, 0);
    @(negedge clk); int_tick = 1'b0; ext_tick = 1'b0;
    wr(8'h60, 32'h0000_0001); rd_check("R6 gate read", 8'h60, 1);
    @(negedge clk); ext_tick = 1'b1; #1;
    check("R6 gate open", lsclk_out_tick, 1);
    @(negedge clk); ext_tick = 1'b0; #1;
    check("R5 ext low", lsclk_tick, 0);
    wr(8'h60, 32'hFFFF_FFFE); rd_check("R6 gate off", 8'h60, 0);
  endtask

  task automatic t_unmapped;
    wr(8'h04, 32'h16AA_0000); wr(8'h0C, 32'h16AA_0000); wr(8'h64, 32'hFFFF_FFFF);
    rd_check("R8 ctrl kept", 8'h00, 1);
    rd_check("R8 gate kept", 8'h60, 0);
    rd_check("R8 read zero", 8'h04, 0);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_key();
    t_divide();
    t_restart();
    t_ext_gate();
    t_unmapped();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule